// File: doc/BRIEF.md
# Overlapping Serial Pattern Detector

This block watches a one-bit serial stream and reports every occurrence of the five-bit pattern 0,1,1,1,0, with the first bit arriving first. Occurrences may overlap, so the closing 0 of one match also serves as the opening 0 of the next. The stream is sampled at a slow rate. An internal prescaler produces that rate from the fast system clock as a one-clock enable pulse. Every flop runs on the single system clock, and no derived signal is ever used as a clock.

When a match completes, a flag output rises and stays high for a fixed number of slow periods. A new match that completes while the flag is still high reloads the hold period. An 8-bit probe bus shows the reset input, the slow enable, the flag and a one-hot picture of the five detector states, so that a logic analyser can follow the machine. At the defaults, a 100 MHz clock is divided by 10000 to give a 10 kHz sampling rate, and the flag is held for two slow periods.

Top module: `serial_pattern_detector`

## Requirements
- R1: While `rst` is high at a rising clock edge, the detector state returns to idle (state index 0), the flag clears and the prescaler count clears. After `rst` falls, the first enable pulse appears `TICK_DIV` clock edges later.
- R2: The slow enable is high for exactly one clock cycle out of every `TICK_DIV` cycles.
- R3: The state and the flag change only at clock edges where the slow enable is high. Changes on `din` in other cycles have no effect.
- R4: The flag rises on the enable edge that samples the final 0 of the bit sequence 0,1,1,1,0 (first bit sampled first).
- R5: Overlapping occurrences are each reported: the stream 011101110 raises the flag twice.
- R6: After each match the flag stays high for exactly `HOLD_TICKS` enable periods (2 by default), then falls.
- R7: Sequences that break the pattern do not raise the flag. Four consecutive 1s send the state back to idle (index 0), and 0110 leaves the state at index 1.
- R8: The probe bus layout is: bit 0 = `rst`, bit 1 = the slow enable, bit 2 = the flag, bits 3 to 7 = one-hot state indices 0 to 4. Index 0 is idle, and index k means the first k bits of the pattern have been seen.
- R9: The enable edge that completes a match moves the state to index 1 (one leading 0 seen).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all flops use its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data, already synchronised to `clk` |
| match_o | output | 1 | Pattern-found flag, held for `HOLD_TICKS` slow periods |
| probe_o | output | 8 | Debug bus: reset, enable, flag and one-hot state |

## Verification
The enable pulse becomes visible on probe bit 1 one cycle after the prescaler count reaches its last value. The state bits and the flag then update at the very next rising edge. The bench sets `din` at a falling edge, waits for a falling edge at which bit 1 is high, and samples the state and the flag at the following falling edge, one register stage later. The reset checks count falling edges after `rst` is released and expect the enable exactly `TICK_DIV` edges later. The check that `din` is ignored toggles the input in cycles without the enable and compares the probe state bits on each of those cycles.

// File: rtl/spd_pkg.sv
package spd_pkg;

    // Detector states: the index equals the number of pattern bits
    // matched so far (0,1,1,1,0 read first bit first).
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_Z    = 3'd1,
        ST_ZO   = 3'd2,
        ST_ZOO  = 3'd3,
        ST_ZOOO = 3'd4
    } det_state_e;

    localparam int NUM_STATES  = 5;
    localparam int PROBE_W     = 8;
    localparam int PROBE_RST   = 0;
    localparam int PROBE_TICK  = 1;
    localparam int PROBE_FLAG  = 2;
    localparam int PROBE_STATE = 3;

endpackage

// File: rtl/spd_prescaler.sv
module spd_prescaler #(
    parameter int DIV = 10000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);

    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } pre_t;

    pre_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.tick = 1'b0;
        if (cur_q.cnt == LAST) begin
            nxt_d.cnt  = '0;
            nxt_d.tick = 1'b1;
        end else begin
            nxt_d.cnt = cur_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign tick_o = cur_q.tick;

    // R2: the enable never lasts two cycles
    a_r2_tick_single: assert property (@(posedge clk) disable iff (rst)
        cur_q.tick |=> !cur_q.tick);

    // R2: the count stays inside its range
    a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cur_q.cnt <= LAST);

    // R2: the enable follows the wrap of the count
    a_r2_tick_after_wrap: assert property (@(posedge clk) disable iff (rst)
        (cur_q.cnt == LAST) |=> (cur_q.tick && cur_q.cnt == '0));

endmodule

// File: rtl/spd_fsm.sv
module spd_fsm
    import spd_pkg::*;
#(
    parameter int HOLD_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       din_i,
    output logic       flag_o,
    output det_state_e state_o
);

    localparam int HOLD_W = $clog2(HOLD_TICKS + 1);
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_TICKS);

    typedef struct packed {
        det_state_e        state;
        logic [HOLD_W-1:0] hold;
    } fsm_t;

    fsm_t cur_q, nxt_d;
    logic found;

    always_comb begin
        nxt_d = cur_q;
        found = 1'b0;
        if (tick_i) begin
            // any 0 is a fresh leading 0, except it also closes a match
            unique case (cur_q.state)
                ST_IDLE: nxt_d.state = din_i ? ST_IDLE : ST_Z;
                ST_Z:    nxt_d.state = din_i ? ST_ZO   : ST_Z;
                ST_ZO:   nxt_d.state = din_i ? ST_ZOO  : ST_Z;
                ST_ZOO:  nxt_d.state = din_i ? ST_ZOOO : ST_Z;
                ST_ZOOO: begin
                    if (din_i) begin
                        nxt_d.state = ST_IDLE;
                    end else begin
                        nxt_d.state = ST_Z;
                        found       = 1'b1;
                    end
                end
                default: nxt_d.state = ST_IDLE;
            endcase
            if (found) begin
                nxt_d.hold = HOLD_LOAD;
            end else if (cur_q.hold != '0) begin
                nxt_d.hold = cur_q.hold - HOLD_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{state: ST_IDLE, hold: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign flag_o  = (cur_q.hold != '0);
    assign state_o = cur_q.state;

    // R3: nothing moves between enable pulses
    a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (!tick_i) |=> (cur_q.state == $past(cur_q.state) && cur_q.hold == $past(cur_q.hold)));

    // R4: a completed pattern raises the flag
    a_r4_match_flags: assert property (@(posedge clk) disable iff (rst)
        (tick_i && cur_q.state == ST_ZOOO && !din_i) |=> flag_o);

    // R9: the closing 0 becomes the next leading 0
    a_r9_reuse_zero: assert property (@(posedge clk) disable iff (rst)
        (tick_i && cur_q.state == ST_ZOOO && !din_i) |=> (cur_q.state == ST_Z));

    // R6: the flag falls when its last hold period ends without a new match
    a_r6_flag_expires: assert property (@(posedge clk) disable iff (rst)
        (tick_i && cur_q.hold == HOLD_W'(1) && !(cur_q.state == ST_ZOOO && !din_i)) |=> !flag_o);

    // R4: the flag never rises without a match
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_o) |-> $past(tick_i && cur_q.state == ST_ZOOO && !din_i));

endmodule

// File: rtl/spd_probe.sv
module spd_probe
    import spd_pkg::*;
(
    input  logic               rst_i,
    input  logic               tick_i,
    input  logic               flag_i,
    input  det_state_e         state_i,
    output logic [PROBE_W-1:0] probe_o
);

    assign probe_o[PROBE_RST]  = rst_i;
    assign probe_o[PROBE_TICK] = tick_i;
    assign probe_o[PROBE_FLAG] = flag_i;

    for (genvar i = 0; i < NUM_STATES; i++) begin : g_state_bit
        assign probe_o[PROBE_STATE+i] = (state_i == det_state_e'(i));
    end

endmodule

// File: rtl/serial_pattern_detector.sv
module serial_pattern_detector
    import spd_pkg::*;
#(
    parameter int TICK_DIV   = 10000,
    parameter int HOLD_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       din,
    output logic       match_o,
    output logic [7:0] probe_o
);

    logic       tick;
    logic       flag;
    det_state_e state;

    spd_prescaler #(.DIV(TICK_DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    spd_fsm #(.HOLD_TICKS(HOLD_TICKS)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .din_i   (din),
        .flag_o  (flag),
        .state_o (state)
    );

    spd_probe u_probe (
        .rst_i   (rst),
        .tick_i  (tick),
        .flag_i  (flag),
        .state_i (state),
        .probe_o (probe_o)
    );

    assign match_o = flag;

    // R8: exactly one state indicator is lit
    a_r8_state_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot(probe_o[PROBE_STATE +: NUM_STATES]));

    // R8: the flag bit of the probe agrees with the flag output
    a_r8_flag_mirror: assert property (@(posedge clk) disable iff (rst)
        probe_o[PROBE_FLAG] == match_o);

endmodule

// File: tb/serial_pattern_detector_test.sv
module serial_pattern_detector_test;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 8;
    localparam int HOLD       = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b1;
    logic       match_o;
    logic [7:0] probe_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    serial_pattern_detector #(.TICK_DIV(DIV), .HOLD_TICKS(HOLD)) uut (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .match_o (match_o),
        .probe_o (probe_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] st(input int idx);
        return 5'(1 << idx);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        din = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // drive one bit, let one enable edge sample it, then check state and flag
    task automatic send_bit(input logic b, input int exp_st, input logic exp_flag, input string req);
        din = b;
        @(negedge clk);
        while (!probe_o[1]) @(negedge clk);
        @(negedge clk);
        check(probe_o[7:3] == st(exp_st), {req, " state"}, probe_o[7:3], st(exp_st));
        check(match_o == exp_flag && probe_o[2] == exp_flag, {req, " flag"}, match_o, exp_flag);
    endtask

    task automatic t_reset();
        int n;
        do_reset();
        send_bit(1'b0, 1, 1'b0, "R7");
        send_bit(1'b1, 2, 1'b0, "R7");
        din = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check(probe_o == 8'h09, "R1 R8 probe in reset", probe_o, 8'h09);
        check(match_o == 1'b0, "R1 flag in reset", match_o, 0);
        rst = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!probe_o[1] && n < 4*DIV);
        check(n == DIV, "R1 first enable after release", n, DIV);
        check(probe_o == 8'h0A, "R8 probe with enable", probe_o, 8'h0A);
    endtask

    task automatic t_tick_period();
        int n;
        do_reset();
        while (!probe_o[1]) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!probe_o[1] && n < 4*DIV);
            check(n == DIV, "R2 enable period", n, DIV);
        end
    endtask

    task automatic t_ignore_off_tick();
        bit moved = 1'b0;
        do_reset();
        @(negedge clk);
        while (!probe_o[1]) begin
            din = ~din;
            if (probe_o[7:3] != st(0)) moved = 1'b1;
            @(negedge clk);
        end
        check(!moved, "R3 state still while no enable", moved, 0);
        din = 1'b0;
        @(negedge clk);
        check(probe_o[7:3] == st(1), "R3 sample on enable", probe_o[7:3], st(1));
    endtask

    task automatic t_match_overlap();
        do_reset();
        send_bit(1'b0, 1, 1'b0, "R4");
        send_bit(1'b1, 2, 1'b0, "R4");
        send_bit(1'b1, 3, 1'b0, "R4");
        send_bit(1'b1, 4, 1'b0, "R4");
        send_bit(1'b0, 1, 1'b1, "R4 R9 first match");
        send_bit(1'b1, 2, 1'b1, "R6 second hold period");
        send_bit(1'b1, 3, 1'b0, "R6 flag expired");
        send_bit(1'b1, 4, 1'b0, "R5");
        send_bit(1'b0, 1, 1'b1, "R5 R9 overlapping match");
        send_bit(1'b0, 1, 1'b1, "R6 hold after second match");
        send_bit(1'b0, 1, 1'b0, "R6 flag expired again");
    endtask

    task automatic t_no_match();
        do_reset();
        send_bit(1'b0, 1, 1'b0, "R7");
        send_bit(1'b1, 2, 1'b0, "R7");
        send_bit(1'b1, 3, 1'b0, "R7");
        send_bit(1'b1, 4, 1'b0, "R7");
        send_bit(1'b1, 0, 1'b0, "R7 four ones to idle");
        send_bit(1'b1, 0, 1'b0, "R7 idle on one");
        send_bit(1'b0, 1, 1'b0, "R7");
        send_bit(1'b1, 2, 1'b0, "R7");
        send_bit(1'b1, 3, 1'b0, "R7");
        send_bit(1'b0, 1, 1'b0, "R7 0110 no match");
    endtask

    initial begin
        t_reset();
        t_tick_period();
        t_ignore_off_tick();
        t_match_overlap();
        t_no_match();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule